// File: doc/BRIEF.md
# Three-Wire-Plus-Output Serial EEPROM Device Model

This block is a synthesizable model of a small serial EEPROM that stores 16-bit words. A host reaches it over four wires: a chip select, a serial clock, a serial data input and a serial data output. It runs on a fast system clock. The serial clock is sampled on that clock, and each of its low-to-high transitions is one bit time. The word array holds 2^ADDR_W words, and ADDR_W is 6 or 8.

With chip select high, a transfer opens with a 1 start bit. A two-bit operation code follows, then the address, MSB first. Writes then carry a 16-bit data word, also MSB first. Reads return a zero placeholder bit and then the stored word. Every operation that changes the array is gated by a write-enable latch. The latch is cleared at reset and is set or cleared by two commands in the extended group. A programming operation runs for BUSY_CYCLES system clocks. During that time the device ignores new start bits. Once chip select has been lowered and raised again, the data output shows busy (0) or ready (1).

Top module: `eep_microwire`

## Requirements
- R1: Zero bits received in idle are ignored. A 1 bit starts a transfer, then two operation bits (first bit is the upper one) and ADDR_W address bits, MSB first.
- R2: Operation code 2'b10 reads. On the rising clock that carries the last address bit, the output goes to 0 (placeholder). Each of the next 16 rising clocks puts one data bit on the output, bit 15 first.
- R3: The write-enable latch is 0 after reset. While it is 0, the array is not changed by WRITE (2'b01), ERASE (2'b11), ERAL (2'b00 with address top bits 2'b10) or WRAL (2'b00 with address top bits 2'b01), and no busy period starts.
- R4: Operation 2'b00 with address top bits 2'b11 sets the write-enable latch. Address top bits 2'b00 clear it. The other address bits are don't-care.
- R5: WRITE (2'b01) takes 16 data bits MSB first after the address and stores them at that address.
- R6: ERASE (2'b11) sets the addressed word to 16'hFFFF.
- R7: ERAL sets every word to 16'hFFFF. WRAL writes its 16-bit data word to every address.
- R8: An accepted programming operation keeps the device busy for exactly BUSY_CYCLES clocks. With chip select high in idle, the output is 0 while busy and 1 once ready. This status is shown until the next accepted start bit.
- R9: Start bits are ignored while the device is busy.
- R10: Chip select low returns the device to idle and drops a partly received transfer without effect. While chip select is low the output is 0.
- R11: After reset every word reads 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial bit clock, rising transition samples |
| di_i | input | 1 | Serial data into the device |
| dout_o | output | 1 | Serial data/status out of the device |

## Verification
The bench aims at the edges of the transfer.

- The placeholder bit before read data is checked. A design that skips it returns every word shifted by one bit.
- Leading zeros before the start bit are sent. Mishandling them would misalign the opcode.
- Programming is attempted with the latch cleared, both before any enable and after a disable. A wrong latch corrupts words that a later read must show unchanged.
- A start bit is sent during the busy window, and the output is then required to show ready in idle. A design that accepts the bit is stuck mid-transfer and shows 0.
- A write is aborted halfway by dropping chip select. A design that does not drop the transfer leaves a changed word behind.

// File: rtl/eep_pkg.sv
package eep_pkg;
   localparam int EEP_DW = 16;

   typedef enum logic [1:0] {
      OP_EXT   = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_ERASE = 2'b11
   } eep_op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_OPC,
      S_ADDR,
      S_DATA,
      S_RDATA,
      S_DONE
   } eep_st_e;

   localparam logic [1:0] XS_EWDS = 2'b00;
   localparam logic [1:0] XS_WRAL = 2'b01;
   localparam logic [1:0] XS_ERAL = 2'b10;
   localparam logic [1:0] XS_EWEN = 2'b11;
endpackage

// File: rtl/eep_edge_det.sv
module eep_edge_det (
   input  logic clk,
   input  logic rst,
   input  logic sig_i,
   output logic rise_o
);
   logic sig_q;

   always_ff @(posedge clk) begin
      if (rst) sig_q <= 1'b0;
      else     sig_q <= sig_i;
   end

   assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
   parameter int CYCLES = 40
) (
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   output logic busy_o
);
   localparam int CW = $clog2(CYCLES + 1);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)               cnt_q <= '0;
      else if (start_i)      cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eep_store.sv
module eep_store #(
   parameter int          AW   = 6,
   parameter int          DW   = 16,
   parameter logic [15:0] INIT = 16'hFFFF
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_one_i,
   input  logic          wr_all_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);
   localparam int DEPTH = 1 << AW;
   logic [DW-1:0] words [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [DW-1:0] word_q;
      always_ff @(posedge clk) begin
         if (rst)
            word_q <= DW'(INIT);
         else if (wr_all_i || (wr_one_i && waddr_i == AW'(i)))
            word_q <= wdata_i;
      end
      assign words[i] = word_q;
   end

   assign rdata_o = words[raddr_i];
endmodule

// File: rtl/eep_microwire.sv
module eep_microwire #(
   parameter int ADDR_W      = 6,
   parameter int BUSY_CYCLES = 40
) (
   input  logic clk,
   input  logic rst,
   input  logic cs_i,
   input  logic sk_i,
   input  logic di_i,
   output logic dout_o
);
   import eep_pkg::*;

   localparam int DW = EEP_DW;
   localparam int CW = $clog2(DW + 1);

   if (!(ADDR_W == 6 || ADDR_W == 8)) begin : g_bad_aw
      $error("eep_microwire: ADDR_W must be 6 or 8");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("eep_microwire: BUSY_CYCLES must be at least 1");
   end

   eep_st_e       st;
   eep_op_e       opc;
   logic [CW-1:0] bitcnt;
   logic [ADDR_W-1:0] addr;
   logic [DW-1:0] shreg;
   logic          rd_bit;
   logic          wen;
   logic          stat_en;
   logic          sk_rise;
   logic          busy;
   logic [DW-1:0] rdata;

   eep_edge_det u_edge (
      .clk    (clk),
      .rst    (rst),
      .sig_i  (sk_i),
      .rise_o (sk_rise)
   );

   // next-state views of the shift registers
   logic [ADDR_W-1:0] addr_nx;
   logic [DW-1:0]     data_nx;
   logic [1:0]        xsel;
   logic              step, at_addr_end, at_data_end;
   logic              l_erase, l_eral, l_write, l_wral, prog;
   logic              wr_one, wr_all;
   logic [ADDR_W-1:0] waddr;
   logic [DW-1:0]     wdata;

   assign addr_nx     = {addr[ADDR_W-2:0], di_i};
   assign data_nx     = {shreg[DW-2:0], di_i};
   assign xsel        = addr_nx[ADDR_W-1 -: 2];
   assign step        = sk_rise & cs_i;
   assign at_addr_end = (st == S_ADDR) && (bitcnt == CW'(ADDR_W - 1));
   assign at_data_end = (st == S_DATA) && (bitcnt == CW'(DW - 1));

   assign l_erase = step && at_addr_end && (opc == OP_ERASE);
   assign l_eral  = step && at_addr_end && (opc == OP_EXT) && (xsel == XS_ERAL);
   assign l_write = step && at_data_end && (opc == OP_WRITE);
   assign l_wral  = step && at_data_end && (opc == OP_EXT);
   assign prog    = wen && (l_erase || l_eral || l_write || l_wral);

   assign wr_one = wen && (l_erase || l_write);
   assign wr_all = wen && (l_eral || l_wral);
   assign waddr  = l_erase ? addr_nx : addr;
   assign wdata  = (l_erase || l_eral) ? '1 : data_nx;

   eep_store #(
      .AW   (ADDR_W),
      .DW   (DW),
      .INIT (16'hFFFF)
   ) u_store (
      .clk      (clk),
      .rst      (rst),
      .wr_one_i (wr_one),
      .wr_all_i (wr_all),
      .waddr_i  (waddr),
      .wdata_i  (wdata),
      .raddr_i  (addr_nx),
      .rdata_o  (rdata)
   );

   eep_busy_timer #(
      .CYCLES (BUSY_CYCLES)
   ) u_busy (
      .clk     (clk),
      .rst     (rst),
      .start_i (prog),
      .busy_o  (busy)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st      <= S_IDLE;
         opc     <= OP_EXT;
         bitcnt  <= '0;
         addr    <= '0;
         shreg   <= '0;
         rd_bit  <= 1'b0;
         wen     <= 1'b0;
         stat_en <= 1'b0;
      end else begin
         if (prog) stat_en <= 1'b1;
         if (!cs_i) begin
            st     <= S_IDLE;
            bitcnt <= '0;
            rd_bit <= 1'b0;
         end else if (sk_rise) begin
            unique case (st)
               S_IDLE: begin
                  if (di_i && !busy) begin
                     st      <= S_OPC;
                     bitcnt  <= '0;
                     stat_en <= 1'b0;
                  end
               end
               S_OPC: begin
                  opc <= eep_op_e'({opc[0], di_i});
                  if (bitcnt == CW'(1)) begin
                     st     <= S_ADDR;
                     bitcnt <= '0;
                  end else begin
                     bitcnt <= bitcnt + 1'b1;
                  end
               end
               S_ADDR: begin
                  addr <= addr_nx;
                  if (at_addr_end) begin
                     bitcnt <= '0;
                     unique case (opc)
                        OP_READ: begin
                           shreg  <= rdata;
                           rd_bit <= 1'b0;
                           st     <= S_RDATA;
                        end
                        OP_WRITE: st <= S_DATA;
                        OP_ERASE: st <= S_DONE;
                        default: begin
                           unique case (xsel)
                              XS_EWEN: begin wen <= 1'b1; st <= S_DONE; end
                              XS_EWDS: begin wen <= 1'b0; st <= S_DONE; end
                              XS_WRAL: st <= S_DATA;
                              default: st <= S_DONE;
                           endcase
                        end
                     endcase
                  end else begin
                     bitcnt <= bitcnt + 1'b1;
                  end
               end
               S_DATA: begin
                  shreg <= data_nx;
                  if (at_data_end) st <= S_DONE;
                  else             bitcnt <= bitcnt + 1'b1;
               end
               S_RDATA: begin
                  if (bitcnt == CW'(DW)) begin
                     st     <= S_DONE;
                     rd_bit <= 1'b0;
                  end else begin
                     rd_bit <= shreg[DW-1];
                     shreg  <= {shreg[DW-2:0], 1'b0};
                     bitcnt <= bitcnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign dout_o = cs_i & ((st == S_RDATA) ? rd_bit
                                           : ((st == S_IDLE) & stat_en & ~busy));
endmodule

// File: rtl/eep_microwire_chk.sv
module eep_microwire_chk #(
   parameter int BUSY_CYCLES = 40
) (
   input logic             clk,
   input logic             rst,
   input logic             cs_i,
   input logic             dout_o,
   input logic             sk_rise,
   input logic             busy,
   input logic             wen,
   input eep_pkg::eep_st_e st
);
   import eep_pkg::*;

   localparam int LW = $clog2(BUSY_CYCLES + 2);
   logic [LW-1:0] blen;

   always_ff @(posedge clk) begin
      if (rst)       blen <= '0;
      else if (busy) blen <= blen + 1'b1;
      else           blen <= '0;
   end

   // R10: output quiet with chip select low
   assert_cs_low_quiet_R10: assert property (@(posedge clk) disable iff (rst)
      !cs_i |-> !dout_o);

   // R3: a busy period starts only with the latch set
   assert_prog_needs_wen_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> wen);

   // R8: busy period length
   assert_busy_len_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> (blen == LW'(BUSY_CYCLES)));

   // R9: no transfer leaves idle while busy
   assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (rst)
      (busy && st == S_IDLE) |=> (st == S_IDLE));

   // R2: read bits move only on serial clock rises
   assert_read_stable_R2: assert property (@(posedge clk) disable iff (rst)
      (st == S_RDATA && $past(st) == S_RDATA && !$past(sk_rise) && cs_i && $past(cs_i))
      |-> $stable(dout_o));
endmodule

bind eep_microwire eep_microwire_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .cs_i    (cs_i),
   .dout_o  (dout_o),
   .sk_rise (sk_rise),
   .busy    (busy),
   .wen     (wen),
   .st      (st)
);

// File: tb/eep_microwire_tb.sv
module eep_microwire_tb;
   localparam int AW   = 6;
   localparam int BUSY = 40;
   localparam int NW   = 1 << AW;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cs = 1'b0, sk = 1'b0, di = 1'b0;
   logic dout;
   int   checks = 0, errors = 0;
   bit   done = 1'b0;
   logic [15:0] model [NW];
   bit   mwen = 1'b0;

   always #2 clk = ~clk;

   eep_microwire #(.ADDR_W(AW), .BUSY_CYCLES(BUSY)) u_dut (
      .clk(clk), .rst(rst), .cs_i(cs), .sk_i(sk), .di_i(di), .dout_o(dout)
   );

   task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sbit(input logic b, output logic o);
      di = b; sk = 1'b0; tick(2);
      sk = 1'b1; tick(2);
      o = dout;
   endtask

   task automatic cs_on();
      cs = 1'b1; sk = 1'b0; di = 1'b0; tick(1);
   endtask

   task automatic cs_off();
      cs = 1'b0; sk = 1'b0; di = 1'b0; tick(2);
   endtask

   task automatic send_hdr(input logic [1:0] op, input logic [AW-1:0] a, output logic last);
      logic o;
      sbit(1'b1, o); sbit(op[1], o); sbit(op[0], o);
      for (int i = AW - 1; i >= 0; i--) sbit(a[i], last);
   endtask

   task automatic do_read(input logic [AW-1:0] a, output logic [15:0] w, output logic dummy);
      logic o;
      cs_on();
      send_hdr(2'b10, a, dummy);
      w = '0;
      for (int i = 0; i < 16; i++) begin sbit(1'b0, o); w = {w[14:0], o}; end
      cs_off();
   endtask

   task automatic do_cmd(input logic [1:0] op, input logic [AW-1:0] a, input bit has_data, input logic [15:0] d);
      logic o;
      cs_on();
      send_hdr(op, a, o);
      if (has_data) for (int i = 15; i >= 0; i--) sbit(d[i], o);
      cs_off();
   endtask

   function automatic logic [AW-1:0] ext_addr(input logic [1:0] sub);
      return {sub, {(AW-2){1'b0}}};
   endfunction

   task automatic wait_ready(input string tag);
      int n = 0;
      cs_on();
      while (dout == 1'b0 && n < BUSY + 20) begin tick(1); n++; end
      check(dout == 1'b1 && n <= BUSY, tag, 16'(n), 16'(BUSY));
      cs_off();
   endtask

   task automatic chk_read(input logic [AW-1:0] a, input string tag);
      logic [15:0] w; logic dm;
      do_read(a, w, dm);
      check(w == model[a], tag, w, model[a]);
   endtask

   task automatic prog_word(input logic [AW-1:0] a, input logic [15:0] d);
      do_cmd(2'b01, a, 1'b1, d);
      if (mwen) begin model[a] = d; wait_ready("R8 ready after write"); end
   endtask

   initial begin
      logic [15:0] w; logic dm, o;
      void'($urandom(32'd7));
      for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
      tick(4); rst = 1'b0; tick(2);

      check(dout == 1'b0, "R10 reset output low", 16'(dout), 16'h0);
      do_read(6'd5, w, dm);
      check(w == 16'hFFFF, "R11 erased after reset", w, 16'hFFFF);
      check(dm == 1'b0, "R2 placeholder bit", 16'(dm), 16'h0);

      // R3: write before any enable is ignored
      do_cmd(2'b01, 6'd3, 1'b1, 16'h1234);
      chk_read(6'd3, "R3 write ignored at reset");

      // R4: enable, then write
      do_cmd(2'b00, ext_addr(2'b11) | 6'h0A, 1'b0, 16'h0);
      mwen = 1'b1;
      do_cmd(2'b01, 6'd3, 1'b1, 16'hA5C3);
      model[3] = 16'hA5C3;
      cs_on();
      check(dout == 1'b0, "R8 busy shows 0", 16'(dout), 16'h0);
      // R9: start bit during busy is ignored
      sbit(1'b1, o); sbit(1'b1, o); sbit(1'b0, o);
      tick(BUSY);
      check(dout == 1'b1, "R9 start ignored while busy", 16'(dout), 16'h1);
      cs_off();
      chk_read(6'd3, "R5 write stored");
      cs_on();
      check(dout == 1'b0, "R8 status cleared by start", 16'(dout), 16'h0);
      cs_off();

      // R1: leading zeros before start bit
      cs_on();
      sbit(1'b0, o); sbit(1'b0, o); sbit(1'b0, o);
      send_hdr(2'b10, 6'd3, dm);
      w = '0;
      for (int i = 0; i < 16; i++) begin sbit(1'b0, o); w = {w[14:0], o}; end
      cs_off();
      check(w == 16'hA5C3, "R1 leading zeros ignored", w, 16'hA5C3);

      // R10: aborted write
      cs_on();
      send_hdr(2'b01, 6'd3, o);
      for (int i = 0; i < 8; i++) sbit(1'b0, o);
      cs_off();
      chk_read(6'd3, "R10 aborted write no effect");

      // R6: erase
      do_cmd(2'b11, 6'd3, 1'b0, 16'h0);
      model[3] = 16'hFFFF;
      wait_ready("R8 ready after erase");
      chk_read(6'd3, "R6 erase sets FFFF");

      // R7: WRAL then ERAL
      do_cmd(2'b00, ext_addr(2'b01), 1'b1, 16'h5A0F);
      for (int i = 0; i < NW; i++) model[i] = 16'h5A0F;
      wait_ready("R8 ready after wral");
      chk_read(6'd0, "R7 wral first word");
      chk_read(6'(NW - 1), "R7 wral last word");
      do_cmd(2'b00, ext_addr(2'b10), 1'b0, 16'h0);
      for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
      wait_ready("R8 ready after eral");
      chk_read(6'd17, "R7 eral word");

      // R4: disable, then programming ignored (R3)
      prog_word(6'd9, 16'h0F0F);
      do_cmd(2'b00, ext_addr(2'b00) | 6'h05, 1'b0, 16'h0);
      mwen = 1'b0;
      do_cmd(2'b01, 6'd9, 1'b1, 16'h1111);
      do_cmd(2'b11, 6'd9, 1'b0, 16'h0);
      do_cmd(2'b00, ext_addr(2'b10), 1'b0, 16'h0);
      chk_read(6'd9, "R4 disable blocks write/erase/eral");

      // random mix
      for (int it = 0; it < 60; it++) begin
         int r = $urandom % 5;
         logic [AW-1:0] a = AW'($urandom);
         logic [15:0] d = 16'($urandom);
         case (r)
            0: chk_read(a, "R2 random read");
            1, 4: prog_word(a, d);
            2: begin
               do_cmd(2'b11, a, 1'b0, 16'h0);
               if (mwen) begin model[a] = 16'hFFFF; wait_ready("R8 ready after erase"); end
            end
            default: begin
               mwen = ($urandom % 3) != 0;
               do_cmd(2'b00, ext_addr(mwen ? 2'b11 : 2'b00), 1'b0, 16'h0);
            end
         endcase
      end
      for (int i = 0; i < NW; i += 5) chk_read(AW'(i), "R5 final sweep");

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule